// File: doc/BRIEF.md
# Dual-Accumulator Integer MAC Unit

This block is a multiply-accumulate datapath with two 40-bit accumulators, A0 and A1. Each operation presents two 32-bit source registers. Each accumulator picks one 16-bit half of each source, high or low, and multiplies the two halves. It then loads, adds or subtracts the product. Both accumulators can change in the same operation, and each has its own half selects and its own operation. The product of A1 can also be taken with a mixed sign, where the half from the first source is read as unsigned.

A0 also drives an integer-mode extraction path. The 16-bit result is twice the updated accumulator value, saturated to the signed 16-bit range. It is merged into the low half of a destination register whose old value comes in on a port. The low 32 bits of both accumulators can always be read back. A clear strobe zeroes both accumulators before a new sequence.

Top module: `dual_acc_mac`

## Requirements
- R1: A select bit of 0 takes bits 15:0 of its source register and a select bit of 1 takes bits 31:16. Each of the four multiplier inputs has its own select bit.
- R2: The operation codes are 2'b00 (leave the accumulator alone), 2'b01 (load the product), 2'b10 (add the product) and 2'b11 (subtract the product).
- R3: The signed 16x16 product enters the accumulator without any shift. For example, 0xFEC7 times 0x5ABD loaded into A0 reads back as 0xFF910EEB.
- R4: The extracted value is two times the updated A0. Above 0x7FFF it becomes 0x7FFF, and below -0x8000 it becomes 0x8000.
- R5: A write to the destination happens when an operation is valid, extraction is enabled and the A0 code is not 2'b00. On a write, dst_we pulses for one cycle, dst_out[15:0] takes the extracted value and dst_out[31:16] takes dst_in[31:16]. Without a write, dst_out holds its value.
- R6: In one valid operation, A0 and A1 update together, each from its own halves and its own operation.
- R7: When a1_mixed is 1, the A1 half taken from src_a is unsigned and the half taken from src_b is signed. A0 is always signed × signed.
- R8: clear zeroes both accumulators on the next edge and deasserts dst_we. It takes priority over a valid operation in the same cycle, and dst_out is left unchanged.
- R9: An add or subtract that would pass the 40-bit signed limits stops at 0x7F_FFFF_FFFF or 0x80_0000_0000.
- R10: With op_valid and clear both low, both accumulators and dst_out hold their values, and dst_we is 0.
- R11: a0_word and a1_word show bits 31:0 of the accumulators. They, dst_out and dst_we reflect an operation right after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero both accumulators |
| op_valid | input | 1 | Operation strobe |
| src_a | input | 32 | First source register |
| src_b | input | 32 | Second source register |
| a0_op | input | 2 | A0 operation code |
| a0_hi_a | input | 1 | A0 half select on src_a |
| a0_hi_b | input | 1 | A0 half select on src_b |
| a1_op | input | 2 | A1 operation code |
| a1_hi_a | input | 1 | A1 half select on src_a |
| a1_hi_b | input | 1 | A1 half select on src_b |
| a1_mixed | input | 1 | A1 takes the src_a half as unsigned |
| ext_en | input | 1 | Write the A0 extraction to the destination |
| dst_in | input | 32 | Previous destination register value |
| dst_out | output | 32 | Merged destination value |
| dst_we | output | 1 | Destination write pulse |
| a0_word | output | 32 | A0 bits 31:0 |
| a1_word | output | 32 | A1 bits 31:0 |

## Verification
Two functions can fall in the same cycle: an A1 update, which may use the mixed sign, and an A0 update that also feeds the saturating extraction. The bench gives both accumulators different halves and different operation codes in one strobe. In some of these strobes A0 saturates the extraction and A1 uses the mixed sign. A reference model of both accumulators, written from the requirements, predicts a0_word, a1_word and the merged destination, and all of them are compared one edge later. A clear raised together with a valid operation checks that the clear wins.

// File: rtl/dual_acc_mac.sv
module dual_acc_mac #(
  parameter int HW    = 16,
  parameter int GUARD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              op_valid,
  input  logic [2*HW-1:0]   src_a,
  input  logic [2*HW-1:0]   src_b,
  input  logic [1:0]        a0_op,
  input  logic              a0_hi_a,
  input  logic              a0_hi_b,
  input  logic [1:0]        a1_op,
  input  logic              a1_hi_a,
  input  logic              a1_hi_b,
  input  logic              a1_mixed,
  input  logic              ext_en,
  input  logic [2*HW-1:0]   dst_in,
  output logic [2*HW-1:0]   dst_out,
  output logic              dst_we,
  output logic [2*HW-1:0]   a0_word,
  output logic [2*HW-1:0]   a1_word
);
  localparam int DW = 2*HW;
  localparam int AW = DW + GUARD;
  localparam int PW = DW + 2;
  localparam int TW = AW - HW + 2;
  localparam logic [1:0] OP_LOAD = 2'b01;
  localparam logic [1:0] OP_ADD  = 2'b10;
  localparam logic [1:0] OP_SUB  = 2'b11;
  localparam logic [DW-1:0] LOW_MASK = {{HW{1'b0}}, {HW{1'b1}}};

  logic signed [AW-1:0] acc0_q, acc1_q, acc0_d, acc1_d, e0, e1;
  logic [HW-1:0] h0a, h0b, h1a, h1b, ext;
  logic signed [PW-1:0] p0, p1;
  logic [TW-1:0] top;
  logic [DW-1:0] dst_q;
  logic we_q;

  function automatic logic signed [AW-1:0] step(input logic signed [AW-1:0] acc,
                                                 input logic signed [AW-1:0] p,
                                                 input logic [1:0] op);
    logic signed [AW:0] s;
    case (op)
      OP_LOAD: s = {p[AW-1], p};
      OP_ADD:  s = {acc[AW-1], acc} + {p[AW-1], p};
      OP_SUB:  s = {acc[AW-1], acc} - {p[AW-1], p};
      default: s = {acc[AW-1], acc};
    endcase
    if (s[AW] != s[AW-1])
      return s[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    return s[AW-1:0];
  endfunction

  assign h0a = a0_hi_a ? src_a[DW-1:HW] : src_a[HW-1:0];
  assign h0b = a0_hi_b ? src_b[DW-1:HW] : src_b[HW-1:0];
  assign h1a = a1_hi_a ? src_a[DW-1:HW] : src_a[HW-1:0];
  assign h1b = a1_hi_b ? src_b[DW-1:HW] : src_b[HW-1:0];

  assign p0 = $signed({h0a[HW-1], h0a}) * $signed({h0b[HW-1], h0b});
  assign p1 = $signed({a1_mixed ? 1'b0 : h1a[HW-1], h1a}) * $signed({h1b[HW-1], h1b});
  assign e0 = {{(AW-PW){p0[PW-1]}}, p0};
  assign e1 = {{(AW-PW){p1[PW-1]}}, p1};

  assign acc0_d = step(acc0_q, e0, a0_op);
  assign acc1_d = step(acc1_q, e1, a1_op);

  assign top = acc0_d[AW-1:HW-2];
  assign ext = (&top || ~|top) ? {acc0_d[HW-2:0], 1'b0}
             : (acc0_d[AW-1] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc0_q <= '0;
      acc1_q <= '0;
      dst_q  <= '0;
      we_q   <= 1'b0;
    end else if (clear) begin
      acc0_q <= '0;
      acc1_q <= '0;
      we_q   <= 1'b0;
    end else if (op_valid) begin
      acc0_q <= acc0_d;
      acc1_q <= acc1_d;
      we_q   <= ext_en && (a0_op != 2'b00);
      if (ext_en && (a0_op != 2'b00))
        dst_q <= (dst_in & ~LOW_MASK) | {{HW{1'b0}}, ext};
    end else begin
      we_q <= 1'b0;
    end
  end

  assign dst_out = dst_q;
  assign dst_we  = we_q;
  assign a0_word = acc0_q[DW-1:0];
  assign a1_word = acc1_q[DW-1:0];
endmodule

module dual_acc_mac_chk #(
  parameter int HW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear,
  input logic            op_valid,
  input logic [1:0]      a0_op,
  input logic            ext_en,
  input logic [2*HW-1:HW] dst_hi_in,
  input logic [2*HW-1:0] dst_out,
  input logic            dst_we,
  input logic [2*HW-1:0] a0_word,
  input logic [2*HW-1:0] a1_word
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !clear) |=> ($stable(a0_word) && $stable(a1_word) && $stable(dst_out) && !dst_we)); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (a0_word == '0 && a1_word == '0 && !dst_we && $stable(dst_out))); // R8
  AST_WRITE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $past(op_valid && !clear && ext_en && (a0_op != 2'b00))); // R5
  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (dst_out[2*HW-1:HW] == $past(dst_hi_in))); // R5
  AST_EXT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> (!dst_out[0] || dst_out[HW-1:0] == {1'b0, {(HW-1){1'b1}}})); // R4
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !clear && a0_op == 2'b00) |=> !dst_we); // R2
endmodule

bind dual_acc_mac dual_acc_mac_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .op_valid(op_valid),
  .a0_op(a0_op), .ext_en(ext_en), .dst_hi_in(dst_in[2*HW-1:HW]),
  .dst_out(dst_out), .dst_we(dst_we), .a0_word(a0_word), .a1_word(a1_word)
);

// File: tb/tb_dual_acc_mac.sv
module tb_dual_acc_mac;
  logic clk = 0, rst_n = 0, clear = 0, op_valid = 0;
  logic [31:0] src_a = 0, src_b = 0, dst_in = 0;
  logic [1:0] a0_op = 0, a1_op = 0;
  logic a0_hi_a = 0, a0_hi_b = 0, a1_hi_a = 0, a1_hi_b = 0, a1_mixed = 0, ext_en = 0;
  logic [31:0] dst_out, a0_word, a1_word;
  logic dst_we;

  int checks = 0, fails = 0;
  bit done = 0;
  longint m0 = 0, m1 = 0;
  logic [31:0] mdst = 0;
  localparam longint AMAX = (64'sd1 <<< 39) - 1;
  localparam longint AMIN = -(64'sd1 <<< 39);

  dual_acc_mac dut (.*);

  always #10 clk = ~clk;

  function automatic longint half(input logic [31:0] r, input logic hi, input bit uns);
    logic [15:0] h = hi ? r[31:16] : r[15:0];
    return uns ? longint'({48'b0, h}) : longint'($signed(h));
  endfunction

  function automatic longint upd(input longint acc, input longint p, input logic [1:0] op);
    longint s;
    case (op)
      2'b01: s = p;
      2'b10: s = acc + p;
      2'b11: s = acc - p;
      default: s = acc;
    endcase
    if (s > AMAX) s = AMAX;
    if (s < AMIN) s = AMIN;
    return s;
  endfunction

  function automatic logic [15:0] xtr(input longint v);
    longint d = 2 * v;
    if (d > 32767) return 16'h7FFF;
    if (d < -32768) return 16'h8000;
    return 16'(d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [31:0] a, input logic [31:0] b,
                    input logic s0a, input logic s0b, input logic [1:0] o0,
                    input logic s1a, input logic s1b, input logic [1:0] o1,
                    input logic mix, input logic ext, input logic [31:0] din);
    bit wr;
    src_a = a; src_b = b; a0_hi_a = s0a; a0_hi_b = s0b; a0_op = o0;
    a1_hi_a = s1a; a1_hi_b = s1b; a1_op = o1; a1_mixed = mix; ext_en = ext; dst_in = din;
    op_valid = 1;
    m0 = upd(m0, half(a, s0a, 0) * half(b, s0b, 0), o0);
    m1 = upd(m1, half(a, s1a, mix) * half(b, s1b, 0), o1);
    wr = ext && (o0 != 2'b00);
    if (wr) mdst = {din[31:16], xtr(m0)};
    @(posedge clk); @(negedge clk);
    op_valid = 0;
    chk({req, " a0"}, a0_word, m0[31:0]);
    chk({req, " a1"}, a1_word, m1[31:0]);
    chk({req, " we"}, {31'b0, dst_we}, {31'b0, wr});
    chk({req, " dst"}, dst_out, mdst);
  endtask

  task automatic do_clear(input bit with_op);
    clear = 1; op_valid = with_op; a0_op = 2'b01; a1_op = 2'b01; ext_en = 1;
    src_a = 32'h12345678; src_b = 32'h7FFF7FFF; dst_in = 32'hAAAA5555;
    m0 = 0; m1 = 0;
    @(posedge clk); @(negedge clk);
    clear = 0; op_valid = 0;
    chk("R8 a0", a0_word, 0);
    chk("R8 a1", a1_word, 0);
    chk("R8 we", {31'b0, dst_we}, 0);
    chk("R8 dst", dst_out, mdst);
  endtask

  task automatic t_reset;
    chk("R11 reset a0", a0_word, 0);
    chk("R11 reset a1", a1_word, 0);
    chk("R5 reset dst", dst_out, 0);
    chk("R5 reset we", {31'b0, dst_we}, 0);
  endtask

  task automatic t_example;
    do_clear(0);
    op("R3", 32'h7FBCFEC7, 32'hF3545ABD, 0, 0, 2'b01, 0, 0, 2'b00, 0, 1, 32'hF3545ABD);
    chk("R3 word", a0_word, 32'hFF910EEB);
    chk("R5 merge", dst_out, 32'hF3548000);
  endtask

  task automatic t_halves;
    op("R1 hh", 32'h0003_0005, 32'h0007_000B, 1, 1, 2'b01, 0, 1, 2'b01, 0, 0, 0);
    chk("R1 hh val", a0_word, 32'd21);
    chk("R1 lh val", a1_word, 32'd35);
    op("R1 hl", 32'h0003_0005, 32'h0007_000B, 1, 0, 2'b01, 1, 0, 2'b01, 0, 0, 0);
    chk("R1 hl val", a0_word, 32'd33);
  endtask

  task automatic t_ops;
    op("R2 load", 32'h0000_0100, 32'h0000_0010, 0, 0, 2'b01, 0, 0, 2'b11, 0, 0, 0);
    op("R2 add", 32'hFFFF_0100, 32'h8000_0010, 1, 1, 2'b10, 0, 0, 2'b10, 0, 1, 32'h1111_2222);
    op("R2 sub", 32'h1234_C7FF, 32'h5678_F679, 0, 0, 2'b11, 1, 1, 2'b11, 0, 1, 32'h3333_4444);
    op("R2 none", 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, 0, 2'b00, 0, 0, 2'b00, 0, 1, 32'h5555_6666);
  endtask

  task automatic t_dual_mixed;
    do_clear(0);
    op("R7 mixed", 32'h0000_FFFF, 32'h0000_0002, 0, 0, 2'b01, 0, 0, 2'b01, 1, 0, 0);
    chk("R7 unsigned", a1_word, 32'h0001_FFFE);
    chk("R7 a0 signed", a0_word, 32'hFFFF_FFFE);
    op("R6 dual", 32'h9F4B_7B69, 32'hA234_877B, 1, 1, 2'b10, 0, 1, 2'b11, 1, 1, 32'hB00C_4887);
    op("R6 dual2", 32'hC78E_A4B8, 32'h1234_6EC7, 0, 1, 2'b11, 1, 0, 2'b10, 0, 1, 32'h4B54_BABD);
  endtask

  task automatic t_extract;
    op("R4 edge pos", 32'h3FFF, 32'h0001, 0, 0, 2'b01, 0, 0, 2'b00, 0, 1, 32'hCAFE0000);
    chk("R4 7FFE", dst_out, 32'hCAFE7FFE);
    op("R4 over pos", 32'h4000, 32'h0001, 0, 0, 2'b01, 0, 0, 2'b00, 0, 1, 32'hBEEF0000);
    chk("R4 7FFF", dst_out, 32'hBEEF7FFF);
    op("R4 edge neg", 32'hC000, 32'h0001, 0, 0, 2'b01, 0, 0, 2'b00, 0, 1, 32'h12340000);
    chk("R4 8000", dst_out, 32'h12348000);
    op("R4 over neg", 32'hBFFF, 32'h0001, 0, 0, 2'b01, 0, 0, 2'b00, 0, 1, 32'h56780000);
    chk("R4 8000b", dst_out, 32'h56788000);
    op("R4 small", 32'hFFFD, 32'h0001, 0, 0, 2'b01, 0, 0, 2'b00, 0, 1, 32'h9ABC0000);
    chk("R4 FFFA", dst_out, 32'h9ABCFFFA);
  endtask

  task automatic t_acc_sat;
    do_clear(0);
    for (int i = 0; i < 513; i++)
      op("R9 up", 32'h8000, 32'h8000, 0, 0, 2'b10, 0, 0, 2'b11, 0, 0, 0);
    chk("R9 top", a0_word, 32'hFFFF_FFFF);
    chk("R9 bottom", a1_word, 32'h0000_0000);
    op("R9 back", 32'h8000, 32'h8000, 0, 0, 2'b11, 0, 0, 2'b10, 0, 1, 32'h0);
    chk("R9 top-1", a0_word, 32'hBFFF_FFFF);
    chk("R9 bottom+1", a1_word, 32'h4000_0000);
    chk("R4 sat dst", dst_out, 32'h0000_7FFF);
  endtask

  task automatic t_hold;
    logic [31:0] s0, s1, sd;
    s0 = a0_word; s1 = a1_word; sd = dst_out;
    src_a = 32'h7FFF7FFF; src_b = 32'h80008000; a0_op = 2'b10; a1_op = 2'b11; ext_en = 1;
    dst_in = 32'hFFFFFFFF; op_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 a0", a0_word, s0);
    chk("R10 a1", a1_word, s1);
    chk("R10 dst", dst_out, sd);
    chk("R10 we", {31'b0, dst_we}, 0);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_example();
    t_halves();
    t_ops();
    t_dual_mixed();
    t_extract();
    t_acc_sat();
    t_hold();
    op("R8 prep", 32'h0100, 32'h0100, 0, 0, 2'b01, 0, 0, 2'b01, 0, 1, 32'h77770000);
    do_clear(1);
    done = 1;
    report();
  end
endmodule